// File: doc/BRIEF.md
# Rising-Edge Event Queue

This block sits between a debounce stage and a slow event consumer. On each tick the producer presents two vectors: a mask of inputs whose debounced level changed, and the current debounced level of every input. The block keeps only the inputs that changed *to* 1. It masks off two inputs, brake and engine-on, because other logic acts on them directly. It then writes one event per remaining input into a small ring buffer.

When a tick carries several rising edges, the block handles them one after another, at one per clock cycle. It takes the highest-numbered input first. The consumer sees the oldest queued event on a show-ahead data output, together with an empty flag, and removes an event by raising `pop`. The buffer never blocks the producer. If a write lands on a full ring, the oldest event is thrown away to make room.

Input bits are assigned as follows: bit 0 left, bit 1 right, bit 2 hazard, bit 3 cancel, bit 4 brake (excluded), bit 5 engine (excluded). An event is the one-hot code of its input, so bit k gives the value 1<<k. The event scanner is a two-state machine:
- `SC_IDLE` waits for a tick. It moves to `SC_SCAN` on the transition *accept* (tick with at least one eligible edge). It stays in `SC_IDLE` on *nothing to do* (tick with no eligible edge, or no tick).
- `SC_SCAN` writes one event per cycle. It stays in `SC_SCAN` on *more pending* and returns to `SC_IDLE` on *last written*.

Top module: `edge_event_queue`

## Requirements
- R1: After a synchronous reset, `q_empty` is 1 and `scan_busy` is 0.
- R2: An input is queued only when its `tog_mask` bit and its `lvl_vec` bit are both 1. Falling edges (toggle set, level 0) add no event.
- R3: Input bits 4 (brake) and 5 (engine) never produce an event, whatever their toggle and level.
- R4: Each event is the one-hot code of its input (bit k gives 1<<k). The events of one tick are written one per cycle, from the highest bit to the lowest. The first is written on the clock edge after the tick is accepted.
- R5: `scan_busy` is 1 from the edge that accepts a tick until the edge that writes its last event. A tick presented while `scan_busy` is 1 is ignored.
- R6: Events leave in the order they were written. `q_head` shows the oldest event whenever `q_empty` is 0.
- R7: The ring has 6 slots and holds up to 5 events. Writing an event while 5 are held discards the oldest one, so the newest 5 remain.
- R8: A `pop` while `q_empty` is 1 has no effect.
- R9: When a write and a pop happen on the same edge, the pop is applied first. With 5 events held, the oldest is removed, the new event is appended, and nothing else is lost.
- R10: Both ring pointers wrap from slot 5 to slot 0, and order is kept across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Toggle mask and level vector are valid this cycle |
| tog_mask | input | 6 | Inputs whose debounced level changed |
| lvl_vec | input | 6 | Current debounced levels |
| scan_busy | output | 1 | Scanner is still writing the events of the last accepted tick |
| pop | input | 1 | Consumer removes the head event |
| q_empty | output | 1 | No event queued |
| q_head | output | 6 | Oldest queued event (one-hot), valid when not empty |

## Verification
If a ring pointer goes wrong, it shows at the ports on the very next `q_head` read. A wrong read pointer shows a stale or uninitialised slot, or an event out of order. A wrong write pointer drops or duplicates an event, which the final `q_empty` check catches. If the full-ring check is applied in the wrong order against a same-edge pop, one event too many is lost, and the drained count comes up one short. If the scanner leaves `SC_SCAN` too early or too late, `scan_busy` is off by a cycle on the edge counted from the accepting tick, or an edge is missed or written twice, which shows as a wrong count.

// File: rtl/eeq_pkg.sv
package eeq_pkg;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_t;

endpackage

// File: rtl/eeq_edge_filter.sv
module eeq_edge_filter #(
    parameter int          W         = 6,
    parameter logic [W-1:0] EXCL_MASK = 6'b110000
) (
    input  logic [W-1:0] tog_mask,
    input  logic [W-1:0] lvl_vec,
    output logic [W-1:0] eligible
);

    // rising edge = changed and now high; excluded inputs forced out
    always_comb begin
        eligible = tog_mask & lvl_vec & ~EXCL_MASK;
    end

endmodule

// File: rtl/eeq_scanner.sv
module eeq_scanner
    import eeq_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] eligible,
    output logic         busy,
    output logic         push_en,
    output logic [W-1:0] push_code
);

    scan_state_t  state_q, state_n;
    logic [W-1:0] pend_q, pend_n;
    logic [W-1:0] pick;

    // highest pending bit wins: ascending loop, last hit kept
    always_comb begin
        pick = '0;
        for (int i = 0; i < W; i++) begin
            if (pend_q[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    always_comb begin
        state_n   = state_q;
        pend_n    = pend_q;
        push_en   = 1'b0;
        push_code = '0;
        busy      = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                if (tick && (|eligible)) begin       // accept
                    pend_n  = eligible;
                    state_n = SC_SCAN;
                end
            end
            SC_SCAN: begin
                busy      = 1'b1;
                push_en   = 1'b1;
                push_code = pick;
                pend_n    = pend_q & ~pick;
                if (pend_n == '0) begin              // last written
                    state_n = SC_IDLE;
                end
            end
            default: begin
                state_n = SC_IDLE;
                pend_n  = '0;
            end
        endcase
    end

endmodule

// File: rtl/eeq_ring.sv
module eeq_ring #(
    parameter int W     = 6,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_code,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [PTR_W-1:0] wptr_n, rptr_n, rptr_after_pop;
    logic             take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty          = (rptr_q == wptr_q);
        head           = slots[rptr_q];
        take           = pop && !empty;
        rptr_after_pop = take ? bump(rptr_q) : rptr_q;
        wptr_n         = push ? bump(wptr_q) : wptr_q;
        // pop first, then overwrite check against the updated read pointer
        rptr_n         = (push && (wptr_n == rptr_after_pop))
                         ? bump(rptr_after_pop) : rptr_after_pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wptr_q <= wptr_n;
            rptr_q <= rptr_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wptr_q] <= push_code;
        end
    end

endmodule

// File: rtl/edge_event_queue.sv
module edge_event_queue #(
    parameter int           W         = 6,
    parameter int           DEPTH     = 6,
    parameter logic [W-1:0] EXCL_MASK = 6'b110000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] tog_mask,
    input  logic [W-1:0] lvl_vec,
    output logic         scan_busy,
    input  logic         pop,
    output logic         q_empty,
    output logic [W-1:0] q_head
);

    logic [W-1:0] eligible;
    logic         push_en;
    logic [W-1:0] push_code;

    eeq_edge_filter #(.W(W), .EXCL_MASK(EXCL_MASK)) filt_i (
        .tog_mask (tog_mask),
        .lvl_vec  (lvl_vec),
        .eligible (eligible)
    );

    eeq_scanner #(.W(W)) scan_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .eligible  (eligible),
        .busy      (scan_busy),
        .push_en   (push_en),
        .push_code (push_code)
    );

    eeq_ring #(.W(W), .DEPTH(DEPTH)) ring_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push_en),
        .push_code (push_code),
        .pop       (pop),
        .empty     (q_empty),
        .head      (q_head)
    );

endmodule

// File: rtl/eeq_checker.sv
module eeq_checker #(
    parameter int           W         = 6,
    parameter int           DEPTH     = 6,
    parameter logic [W-1:0] EXCL_MASK = 6'b110000
) (
    input logic         clk,
    input logic         rst,
    input logic         pop,
    input logic         q_empty,
    input logic         scan_busy,
    input logic         push_en,
    input logic [W-1:0] push_code
);

    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH - 1);

    logic [OCC_W-1:0] occ;

    // independent occupancy model built from the handshake alone
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            if (push_en && !(pop && !q_empty) && occ == OCC_MAX) occ <= occ;
            else occ <= occ + OCC_W'(push_en) - OCC_W'(pop && !q_empty);
        end
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q_empty && !scan_busy));

    // R3
    a_r3_no_excluded: assert property (@(posedge clk) disable iff (rst)
        push_en |-> ((push_code & EXCL_MASK) == '0));

    // R4
    a_r4_onehot_code: assert property (@(posedge clk) disable iff (rst)
        push_en |-> ($countones(push_code) == 1));

    // R4
    a_r4_descending: assert property (@(posedge clk) disable iff (rst)
        (push_en && $past(push_en) && scan_busy && $past(scan_busy))
        |-> (push_code < $past(push_code)));

    // R6
    a_r6_push_fills: assert property (@(posedge clk) disable iff (rst)
        push_en |=> !q_empty);

    // R7
    a_r7_occ_matches: assert property (@(posedge clk) disable iff (rst)
        q_empty == (occ == '0));

    // R8
    a_r8_pop_empty_noop: assert property (@(posedge clk) disable iff (rst)
        (q_empty && !push_en) |=> q_empty);

endmodule

bind edge_event_queue eeq_checker #(.W(W), .DEPTH(DEPTH), .EXCL_MASK(EXCL_MASK)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pop       (pop),
    .q_empty   (q_empty),
    .scan_busy (scan_busy),
    .push_en   (push_en),
    .push_code (push_code)
);

// File: tb/edge_event_queue_tb_top.sv
module edge_event_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [5:0] tog_mask = '0;
    logic [5:0] lvl_vec = '0;
    logic       pop = 1'b0;
    logic       scan_busy, q_empty;
    logic [5:0] q_head;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_event_queue dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tog_mask  (tog_mask),
        .lvl_vec   (lvl_vec),
        .scan_busy (scan_busy),
        .pop       (pop),
        .q_empty   (q_empty),
        .q_head    (q_head)
    );

    // {toggle, level, count, code0, code1, code2, code3}
    localparam logic [39:0] VEC [NVEC] = '{
        {6'h0F, 6'h0F, 4'd4, 6'h08, 6'h04, 6'h02, 6'h01},  // R4 all four
        {6'h0F, 6'h00, 4'd0, 6'h00, 6'h00, 6'h00, 6'h00},  // R2 falling
        {6'h30, 6'h30, 4'd0, 6'h00, 6'h00, 6'h00, 6'h00},  // R3 brake+engine
        {6'h30, 6'h10, 4'd0, 6'h00, 6'h00, 6'h00, 6'h00},  // R3 brake only
        {6'h05, 6'h04, 4'd1, 6'h04, 6'h00, 6'h00, 6'h00},  // R2 mixed
        {6'h0A, 6'h0F, 4'd2, 6'h08, 6'h02, 6'h00, 6'h00},  // R2 toggle gates
        {6'h3F, 6'h3B, 4'd3, 6'h08, 6'h02, 6'h01, 6'h00},  // R3 excluded among
        {6'h01, 6'h01, 4'd1, 6'h01, 6'h00, 6'h00, 6'h00},  // R10 wraps
        {6'h0F, 6'h05, 4'd2, 6'h04, 6'h01, 6'h00, 6'h00}   // R6 order
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 12; i++) begin
            if (!scan_busy) break;
            cyc();
        end
    endtask

    task automatic apply_tick(input logic [5:0] t, input logic [5:0] l);
        tick = 1'b1; tog_mask = t; lvl_vec = l;
        cyc();
        tick = 1'b0; tog_mask = '0; lvl_vec = '0;
    endtask

    // codes packed first-out in the top six bits
    task automatic drain(input int n, input logic [29:0] codes, input string req);
        for (int i = 0; i < n; i++) begin
            logic [5:0] e;
            e = codes[29 - 6 * i -: 6];
            check(!q_empty && q_head == e, req, {q_empty, q_head}, e);
            pop = 1'b1;
            cyc();
            pop = 1'b0;
        end
        check(q_empty == 1'b1, req, q_empty, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        // R1 reset state
        check(q_empty && !scan_busy, "R1", {q_empty, scan_busy}, 2'b10);

        // table walk: R2 R3 R4 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            apply_tick(VEC[v][39:34], VEC[v][33:28]);
            wait_idle();
            drain(int'(VEC[v][27:24]), {VEC[v][23:0], 6'h00}, "R2/R3/R4/R6/R10 table");
        end

        // R4 cycle timing and R5 busy window
        tick = 1'b1; tog_mask = 6'h0F; lvl_vec = 6'h0F;
        cyc();                                    // accept edge
        tick = 1'b0;
        check(scan_busy && q_empty, "R4 no write on accept edge", {scan_busy, q_empty}, 2'b11);
        cyc();
        check(!q_empty && q_head == 6'h08, "R4 first write next edge", q_head, 8'h08);
        cyc(); cyc();
        check(scan_busy == 1'b1, "R5 busy before last write", scan_busy, 1);
        cyc();
        check(scan_busy == 1'b0, "R5 idle after last write", scan_busy, 0);
        drain(4, {6'h08, 6'h04, 6'h02, 6'h01, 6'h00}, "R4 order");

        // R5 tick while busy ignored
        apply_tick(6'h0F, 6'h0F);
        tick = 1'b1; tog_mask = 6'h01; lvl_vec = 6'h01;
        cyc();
        tick = 1'b0;
        wait_idle();
        drain(4, {6'h08, 6'h04, 6'h02, 6'h01, 6'h00}, "R5 busy tick");

        // R8 pop on empty
        pop = 1'b1;
        cyc();
        pop = 1'b0;
        check(q_empty == 1'b1, "R8 still empty", q_empty, 1);
        apply_tick(6'h02, 6'h02);
        wait_idle();
        drain(1, {6'h02, 24'h0}, "R8 after empty pop");

        // R7 overflow drops oldest
        apply_tick(6'h0F, 6'h0F);
        wait_idle();
        apply_tick(6'h0C, 6'h0C);
        wait_idle();
        check(!q_empty && q_head == 6'h04, "R7 oldest dropped", q_head, 6'h04);

        // R9 write and pop on the same edge with five held
        tick = 1'b1; tog_mask = 6'h01; lvl_vec = 6'h01;
        cyc();
        tick = 1'b0; pop = 1'b1;
        cyc();
        pop = 1'b0;
        wait_idle();
        drain(5, {6'h02, 6'h01, 6'h08, 6'h04, 6'h01}, "R9 pop before overwrite");

        // R1 reset mid-run empties the ring
        apply_tick(6'h03, 6'h03);
        wait_idle();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        check(q_empty && !scan_busy, "R1 reset flush", {q_empty, scan_busy}, 2'b10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule